// File: doc/BRIEF.md
# Cascaded Video Layer Compositor

This block is one stage in a chain of video boards that share a single raster. It receives a 24-bit RGB pixel stream, with its horizontal sync, vertical sync and data-enable, from the board upstream. It runs on the pixel clock that travels with that stream. The block merges the incoming stream with the pixels its own board generates and sends the merged stream downstream, together with the syncs.

Colours are never mixed arithmetically. For each pixel position exactly one layer wins. A local pixel that equals a programmable key colour is transparent. An opaque local pixel either always covers the upstream pixel, or covers it only where the upstream pixel is itself the key colour, depending on a one-bit priority input.

The local stream starts earlier than the upstream stream by a fixed number of pixel clocks. A register chain of parameterised depth delays it by that whole number of cycles, so that both streams refer to the same screen position when they meet.

Top module: `layer_compositor`

## Requirements
- R1: An upstream pixel presented at clock edge n reaches `dn_rgb` after edge n+2, and no earlier. Exactly two register stages lie on that path.
- R2: A local pixel presented at edge m is merged with the upstream pixel presented at edge m+LOCAL_DELAY. LOCAL_DELAY is a parameter from 0 to 15.
- R3: A local pixel is transparent when its data-enable is 0 or its value equals `key_rgb`. A transparent local pixel lets the upstream pixel pass through unchanged.
- R4: When `loc_on_top` is 1 and the local pixel is opaque, the output is the local pixel.
- R5: When `loc_on_top` is 0, the upstream pixel wins unless it equals `key_rgb`, in which case an opaque local pixel is shown. `key_rgb` and `loc_on_top` apply to the upstream pixel presented in the same cycle.
- R6: When the upstream data-enable is 0, the output RGB is 0x000000.
- R7: `dn_hs`, `dn_vs` and `dn_de` equal `up_hs`, `up_vs` and `up_de` as presented two edges earlier. Syncs are active-high.
- R8: Synchronous active-high `rst` clears every pipeline register: all outputs read 0 after an edge with `rst` high. The local delay chain also reads as transparent until new pixels refill it.
- R9: `dn_rgb` is always one of three values: 0, the upstream pixel, or the aligned local pixel. It is never a combination of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock forwarded with the upstream stream |
| rst | input | 1 | Synchronous active-high reset |
| up_rgb | input | 24 | Upstream pixel, R in [23:16], G in [15:8], B in [7:0] |
| up_hs | input | 1 | Upstream horizontal sync |
| up_vs | input | 1 | Upstream vertical sync |
| up_de | input | 1 | Upstream active-area flag |
| loc_rgb | input | 24 | Locally generated pixel |
| loc_de | input | 1 | Local active-area flag |
| key_rgb | input | 24 | Transparent key colour |
| loc_on_top | input | 1 | 1: local layer covers upstream; 0: local shows only through keyed upstream pixels |
| dn_rgb | output | 24 | Composite pixel to the next board |
| dn_hs | output | 1 | Horizontal sync to the next board |
| dn_vs | output | 1 | Vertical sync to the next board |
| dn_de | output | 1 | Active-area flag to the next board |

## Verification
A wrong depth or a stale entry in the local delay chain shows at the ports as local objects drawn shifted sideways along the line. With a palette that makes keyed and opaque pixels frequent, this is detected within LOCAL_DELAY+2 cycles of the first opaque local pixel. A wrong selection term shows as the wrong layer winning where layers overlap, on the very pixel concerned. A misaligned sync or data-enable register shows as a one-cycle shift between `dn_de` and the black borders. The bench compares every output on every cycle against a model built from the input history. A mid-run reset checks that no pre-reset local pixel leaks through once the chain restarts.

// File: rtl/comp_pkg.sv
package comp_pkg;
  localparam int CH_W  = 8;
  localparam int RGB_W = 3 * CH_W;

  typedef logic [RGB_W-1:0] rgb_t;

  // one beat of a video stream
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
    rgb_t rgb;
  } vid_t;

  // everything that stage 1 captures in one pixel cycle
  typedef struct packed {
    vid_t up;
    logic loc_de;
    rgb_t loc_rgb;
    rgb_t key;
    logic top;
  } stage1_t;

  function automatic logic matches_key(rgb_t px, rgb_t key);
    return px == key;
  endfunction

  // a layer is see-through when it is outside its active area or keyed out
  function automatic logic see_through(rgb_t px, logic de, rgb_t key);
    return !de || matches_key(px, key);
  endfunction
endpackage

// File: rtl/stream_delay.sv
module stream_delay #(
  parameter int WIDTH = 25,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_chain
      logic [WIDTH-1:0] taps [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) taps[0] <= '0;
        else     taps[0] <= din;
      end
      for (genvar k = 1; k < DEPTH; k++) begin : g_tap
        always_ff @(posedge clk) begin
          if (rst) taps[k] <= '0;
          else     taps[k] <= taps[k-1];
        end
      end
      assign dout = taps[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/layer_select.sv
module layer_select
  import comp_pkg::*;
(
  input  rgb_t up_rgb,
  input  logic up_de,
  input  rgb_t loc_rgb,
  input  logic loc_de,
  input  rgb_t key_rgb,
  input  logic loc_top,
  output rgb_t mix_rgb,
  output logic loc_clear,
  output logic up_keyed,
  output logic take_local
);
  assign loc_clear  = see_through(loc_rgb, loc_de, key_rgb);
  assign up_keyed   = matches_key(up_rgb, key_rgb);
  assign take_local = !loc_clear && (loc_top || up_keyed);

  always_comb begin
    if (!up_de)          mix_rgb = '0;
    else if (take_local) mix_rgb = loc_rgb;
    else                 mix_rgb = up_rgb;
  end
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import comp_pkg::*;
#(
  parameter int LOCAL_DELAY = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [23:0] up_rgb,
  input  logic        up_hs,
  input  logic        up_vs,
  input  logic        up_de,
  input  logic [23:0] loc_rgb,
  input  logic        loc_de,
  input  logic [23:0] key_rgb,
  input  logic        loc_on_top,
  output logic [23:0] dn_rgb,
  output logic        dn_hs,
  output logic        dn_vs,
  output logic        dn_de
);
  localparam int LOC_W = RGB_W + 1;
  localparam int S1_W  = $bits(stage1_t);

  // local stream alignment
  logic [LOC_W-1:0] loc_in, loc_aligned;
  assign loc_in = {loc_de, loc_rgb};

  stream_delay #(.WIDTH(LOC_W), .DEPTH(LOCAL_DELAY)) u_loc_align (
    .clk (clk), .rst (rst), .din (loc_in), .dout (loc_aligned)
  );

  // stage 1: capture upstream beat, aligned local beat and controls together
  stage1_t s1_in, s1_q;
  logic [S1_W-1:0] s1_bits;

  assign s1_in.up.hs   = up_hs;
  assign s1_in.up.vs   = up_vs;
  assign s1_in.up.de   = up_de;
  assign s1_in.up.rgb  = up_rgb;
  assign s1_in.loc_de  = loc_aligned[LOC_W-1];
  assign s1_in.loc_rgb = loc_aligned[RGB_W-1:0];
  assign s1_in.key     = key_rgb;
  assign s1_in.top     = loc_on_top;

  stream_delay #(.WIDTH(S1_W), .DEPTH(1)) u_stage1 (
    .clk (clk), .rst (rst), .din (s1_in), .dout (s1_bits)
  );
  assign s1_q = s1_bits;

  // named stage-1 signals for the checker
  rgb_t s1_up_rgb, s1_loc_rgb, s1_key;
  logic s1_up_de, s1_loc_de, s1_top;
  assign s1_up_rgb  = s1_q.up.rgb;
  assign s1_up_de   = s1_q.up.de;
  assign s1_loc_rgb = s1_q.loc_rgb;
  assign s1_loc_de  = s1_q.loc_de;
  assign s1_key     = s1_q.key;
  assign s1_top     = s1_q.top;

  // layer decision
  rgb_t mix_rgb;
  logic loc_clear, up_keyed, take_local;

  layer_select u_select (
    .up_rgb     (s1_up_rgb),
    .up_de      (s1_up_de),
    .loc_rgb    (s1_loc_rgb),
    .loc_de     (s1_loc_de),
    .key_rgb    (s1_key),
    .loc_top    (s1_top),
    .mix_rgb    (mix_rgb),
    .loc_clear  (loc_clear),
    .up_keyed   (up_keyed),
    .take_local (take_local)
  );

  // stage 2: output register
  always_ff @(posedge clk) begin
    if (rst) begin
      dn_rgb <= '0;
      dn_hs  <= 1'b0;
      dn_vs  <= 1'b0;
      dn_de  <= 1'b0;
    end else begin
      dn_rgb <= mix_rgb;
      dn_hs  <= s1_q.up.hs;
      dn_vs  <= s1_q.up.vs;
      dn_de  <= s1_q.up.de;
    end
  end
endmodule

// File: rtl/compositor_checker.sv
module compositor_checker (
  input logic        clk,
  input logic        rst,
  input logic        up_hs,
  input logic        up_vs,
  input logic        up_de,
  input logic [23:0] dn_rgb,
  input logic        dn_hs,
  input logic        dn_vs,
  input logic        dn_de,
  input logic [23:0] s1_up_rgb,
  input logic        s1_up_de,
  input logic [23:0] s1_loc_rgb,
  input logic        s1_loc_de,
  input logic [23:0] s1_key,
  input logic        s1_top
);
  // cycles since reset, saturating at 3
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)              warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  logic loc_opaque;
  assign loc_opaque = s1_loc_de && (s1_loc_rgb != s1_key);

  // R6: black outside the active area
  a_r6_black_outside: assert property (@(posedge clk) disable iff (rst)
    !dn_de |-> dn_rgb == 24'h0);

  // R7, R1: syncs and data-enable lag the upstream inputs by two edges
  a_r7_sync_lag: assert property (@(posedge clk) disable iff (rst)
    warm >= 2'd2 |-> (dn_hs == $past(up_hs, 2) && dn_vs == $past(up_vs, 2)
                      && dn_de == $past(up_de, 2)));

  // R9: output is a selection, never a blend
  a_r9_no_blend: assert property (@(posedge clk) disable iff (rst)
    warm >= 2'd1 |-> (dn_rgb == 24'h0 || dn_rgb == $past(s1_up_rgb)
                      || dn_rgb == $past(s1_loc_rgb)));

  // R3: transparent local passes the upstream pixel
  a_r3_clear_passes: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd1 && $past(s1_up_de && !loc_opaque)) |-> dn_rgb == $past(s1_up_rgb));

  // R4: opaque local on top wins
  a_r4_local_on_top: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd1 && $past(s1_up_de && loc_opaque && s1_top)) |-> dn_rgb == $past(s1_loc_rgb));

  // R5: local underneath shows only through a keyed upstream pixel
  a_r5_local_below: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd1 && $past(s1_up_de && loc_opaque && !s1_top))
      |-> dn_rgb == ($past(s1_up_rgb == s1_key) ? $past(s1_loc_rgb) : $past(s1_up_rgb)));

  // R8: first cycle after reset shows cleared outputs
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dn_rgb == 24'h0 && !dn_hs && !dn_vs && !dn_de));
endmodule

bind layer_compositor compositor_checker i_chk (
  .clk        (clk),
  .rst        (rst),
  .up_hs      (up_hs),
  .up_vs      (up_vs),
  .up_de      (up_de),
  .dn_rgb     (dn_rgb),
  .dn_hs      (dn_hs),
  .dn_vs      (dn_vs),
  .dn_de      (dn_de),
  .s1_up_rgb  (s1_up_rgb),
  .s1_up_de   (s1_up_de),
  .s1_loc_rgb (s1_loc_rgb),
  .s1_loc_de  (s1_loc_de),
  .s1_key     (s1_key),
  .s1_top     (s1_top)
);

// File: tb/test_layer_compositor.sv
module test_layer_compositor;
  localparam int D     = 3;
  localparam int NCYC  = 2400;
  localparam int HMAX  = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] up_rgb = '0, loc_rgb = '0, key_rgb = 24'hFF00FF;
  logic        up_hs = 0, up_vs = 0, up_de = 0, loc_de = 0, loc_on_top = 0;
  logic [23:0] dn_rgb;
  logic        dn_hs, dn_vs, dn_de;

  always #2.5 clk = ~clk;  // 200 MHz

  layer_compositor #(.LOCAL_DELAY(D)) i_layer_compositor (
    .clk, .rst, .up_rgb, .up_hs, .up_vs, .up_de, .loc_rgb, .loc_de,
    .key_rgb, .loc_on_top, .dn_rgb, .dn_hs, .dn_vs, .dn_de
  );

  // input history, one entry per rising edge
  logic [23:0] h_up [HMAX];
  logic [23:0] h_loc[HMAX];
  logic [23:0] h_key[HMAX];
  logic        h_hs [HMAX], h_vs[HMAX], h_de[HMAX], h_lde[HMAX], h_top[HMAX], h_rst[HMAX];
  int edges = 0;

  always @(posedge clk) begin
    if (edges < HMAX) begin
      h_up[edges] = up_rgb;   h_loc[edges] = loc_rgb; h_key[edges] = key_rgb;
      h_hs[edges] = up_hs;    h_vs[edges]  = up_vs;   h_de[edges]  = up_de;
      h_lde[edges] = loc_de;  h_top[edges] = loc_on_top; h_rst[edges] = rst;
    end
    edges++;
  end

  int compared = 0, mismatched = 0;
  bit summary_done = 0;

  task automatic report;
    if (!summary_done) begin
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // expected outputs after edge n, from requirements only
  task automatic model(input int n, output logic [23:0] e_rgb, output logic e_hs,
                       output logic e_vs, output logic e_de, output string tag);
    int u, m;
    bit loc_gone, loc_clear;
    e_rgb = '0; e_hs = 0; e_vs = 0; e_de = 0;
    if (h_rst[n]) begin tag = "R8"; return; end
    if (n < 1 || h_rst[n-1]) begin tag = "R8"; return; end
    u = n - 1;                      // R1: two edges from upstream input to output
    m = u - D;                      // R2: local pixel presented D edges earlier
    loc_gone = (m < 0);
    for (int k = (m < 0 ? 0 : m); k <= u; k++) if (h_rst[k]) loc_gone = 1;
    e_hs = h_hs[u]; e_vs = h_vs[u]; e_de = h_de[u];
    if (!h_de[u]) begin tag = "R6"; return; end
    loc_clear = loc_gone || !h_lde[m] || (h_loc[m] == h_key[u]);
    if (loc_clear)                   begin e_rgb = h_up[u];  tag = "R3"; end
    else if (h_top[u])               begin e_rgb = h_loc[m]; tag = "R4"; end
    else if (h_up[u] == h_key[u])    begin e_rgb = h_loc[m]; tag = "R5"; end
    else                             begin e_rgb = h_up[u];  tag = "R5"; end
  endtask

  // R9 holds whenever every compare below matches: the model only ever picks a whole layer
  task automatic check_now;
    logic [23:0] e_rgb; logic e_hs, e_vs, e_de; string tag;
    int n = edges - 1;
    if (n < 0 || n >= HMAX) return;
    model(n, e_rgb, e_hs, e_vs, e_de, tag);
    compared++;
    if (dn_rgb !== e_rgb) begin
      mismatched++;
      $display("FAIL %s cycle %0d dn_rgb actual %h expected %h", tag, n, dn_rgb, e_rgb);
    end
    compared++;
    if ({dn_hs, dn_vs, dn_de} !== {e_hs, e_vs, e_de}) begin
      mismatched++;
      $display("FAIL %s cycle %0d syncs hs/vs/de actual %b%b%b expected %b%b%b",
               (tag == "R8") ? "R8" : "R7", n, dn_hs, dn_vs, dn_de, e_hs, e_vs, e_de);
    end
  endtask

  function automatic logic [23:0] palette(int k, logic [23:0] key);
    case (k % 6)
      0, 5:    return key;
      1:       return 24'hFF0000;
      2:       return 24'h0000FF;
      3:       return 24'h00FF00;
      default: return 24'($urandom);
    endcase
  endfunction

  initial begin
    for (int i = 0; i < NCYC; i++) begin
      @(negedge clk);
      check_now();
      rst = (i < 6) || (i >= 1500 && i < 1504);          // R8 at start and mid-run
      if (i >= 1800 && i % 100 == 0) key_rgb = (i % 200 == 0) ? 24'h000000 : 24'h123456;
      if (i < 600)        loc_on_top = 1'b1;               // R4
      else if (i < 1200)  loc_on_top = 1'b0;               // R5
      else                loc_on_top = 1'($urandom);
      up_hs  = (i % 100) < 4;
      up_vs  = (i % 1000) < 8;
      up_de  = (i % 100) >= 20;                            // R6 borders
      loc_de = ($urandom % 10) != 0;                       // R3 via local de
      up_rgb  = palette(int'($urandom % 6), key_rgb);
      loc_rgb = palette(int'($urandom % 6), key_rgb);
    end
    @(negedge clk);
    check_now();
    report();
  end

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog expired");
    report();
  end
endmodule